// File: doc/BRIEF.md
# CAN Transmit Mailbox Controller

This block holds three outgoing CAN frames in transmit mailboxes and presents them one at a time to a frame transmitter. Software fills a mailbox through a 32-bit word register port (identifier word, length word and two data words), then sets the request bit in the identifier word. The controller tracks each mailbox as empty or pending, picks the next pending mailbox to offer, and records the outcome of every attempt in a packed status word. Software reads and clears that word, and an interrupt line can follow it.

The transmitter is modelled as a simple handshake. The controller raises `tx_req` together with the frame fields and the mailbox index. The transmitter answers with a one-cycle `tx_done` and the result on `tx_ok`. Two selection policies are available: lowest identifier first, or oldest request first. A failed attempt is offered again unless the no-retransmission control bit is set. Software can abort a pending mailbox, whether it is waiting or in flight.

Top module: `can_txmb_ctrl`

## Requirements
- R1: After reset every mailbox is empty. The status word (word address 1) reads 0x1C000000, the control word (address 0) reads 0, and `tx_req` and `irq` are 0.
- R2: Mailbox m (m = 0..2) has its identifier, length, data-low and data-high words at word addresses 4+4m, 5+4m, 6+4m and 7+4m. Writing the identifier word with bit 0 set while the mailbox is empty makes it pending: empty bit 26+m reads 0 and identifier bit 0 reads 1. The mailbox is then offered with `tx_req`=1, `tx_mbox`=m, `tx_ident` = identifier word with bit 0 cleared, `tx_dlc` = length bits 3:0, and `tx_data` = {data-high, data-low}. These outputs hold until `tx_done`.
- R3: `tx_done` with `tx_ok`=1 sets the mailbox's complete bit (8m) and ok bit (8m+1), sets its empty bit, and drops `tx_req`.
- R4: `tx_done` with `tx_ok`=0 leaves the mailbox pending and offers it again when control bit 1 (no retransmission) is 0. When control bit 1 is 1, the same failure sets complete=1, ok=0 and empty=1.
- R5: Writing 1 to a complete bit in the status word clears that mailbox's complete and ok bits. Writing 0 changes nothing.
- R6: Writing 1 to status bit 8m+7 aborts pending mailbox m. If the mailbox is waiting, it completes at once with complete=1, ok=0, empty=1. If it is in flight, bit 8m+7 reads 1 until `tx_done`. A failure then completes it as failed even when retransmission is on, and a success completes it as OK. An abort aimed at an empty mailbox has no effect.
- R7: With control bit 0 = 0, the pending mailbox with the lowest identifier-word bits 31:3 is offered next. Ties go to the lowest mailbox index.
- R8: With control bit 0 = 1, the pending mailbox whose request was set earliest is offered next.
- R9: Writes to any word of a mailbox that is not empty are ignored.
- R10: `irq` is 1 exactly when control bit 2 is 1 and at least one complete bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| tx_req | output | 1 | A frame is offered to the transmitter |
| tx_mbox | output | 2 | Index of the offered mailbox |
| tx_ident | output | 32 | Identifier word of the offered frame, bit 0 zero |
| tx_dlc | output | 4 | Data length code of the offered frame |
| tx_data | output | 64 | Data bytes 7..0 of the offered frame, byte 0 lowest |
| tx_done | input | 1 | Transmitter finished the current attempt |
| tx_ok | input | 1 | Attempt succeeded (valid with tx_done) |
| irq | output | 1 | Transmit completion interrupt |

## Verification
The bench queues three requests while the transmitter is busy, so the selection among the two that remain is visible. The cases are chosen so that identifier order and request order point at different mailboxes, plus an all-equal identifier tie. A selector that ignored the mode bit, or broke ties toward the highest index, would offer the wrong mailbox second. Aborts are tested in three places: on a waiting mailbox, on an in-flight mailbox that then fails with retransmission on (a design that forgot the abort would retry forever), and on an empty mailbox (which must leave the status word alone). Writes to a busy mailbox and zero-writes to the status word are read back to show they changed nothing.

// File: rtl/can_txmb_pkg.sv
package can_txmb_pkg;
    localparam int MB_N        = 3;
    localparam int MB_IW       = 2;
    localparam int KEY_W       = 29;
    localparam int DLC_W       = 4;
    localparam int WORD_W      = 32;
    localparam int A_CTRL      = 0;
    localparam int A_STAT      = 1;
    localparam int A_MB_BASE   = 4;
    localparam int MB_STRIDE   = 4;
    localparam int W_ID        = 0;
    localparam int W_LEN       = 1;
    localparam int W_DLO       = 2;
    localparam int W_DHI       = 3;
    localparam int ST_STRIDE   = 8;
    localparam int ST_OK_OFS   = 1;
    localparam int ST_AB_OFS   = 7;
    localparam int ST_EMP_BASE = 26;

    typedef struct packed {
        logic [WORD_W-1:1] id;
        logic [DLC_W-1:0]  dlc;
        logic [WORD_W-1:0] dlo;
        logic [WORD_W-1:0] dhi;
    } mbox_t;

    typedef struct packed {
        logic             order_mode;
        logic             no_retx;
        logic             irq_en;
        logic [MB_N-1:0]  empty;
        logic [MB_N-1:0]  rqcp;
        logic [MB_N-1:0]  txok;
        logic [MB_N-1:0]  abrq;
        mbox_t [MB_N-1:0] mb;
        logic             busy;
        logic [MB_IW-1:0] cur;
    } ctl_st_t;
endpackage

// File: rtl/can_txmb_age.sv
module can_txmb_age #(
    parameter int N = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N-1:0]          set,
    output logic [N-1:0][N-1:0]   older
);
    logic [N-1:0][N-1:0] older_d, older_q;
    logic                conflict;

    always_comb begin
        older_d = older_q;
        for (int i = 0; i < N; i++) begin
            if (set[i]) begin
                for (int j = 0; j < N; j++) begin
                    if (j != i) begin
                        older_d[i][j] = 1'b0;
                        older_d[j][i] = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) older_q <= '0;
        else        older_q <= older_d;
    end

    assign older = older_q;

    always_comb begin
        conflict = 1'b0;
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                if (older_q[i][j] && older_q[j][i]) conflict = 1'b1;
    end

    // R8
    age_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(set));
    // R8
    age_order_chk: assert property (@(posedge clk) disable iff (!rst_n) !conflict);
endmodule

// File: rtl/can_txmb_arb.sv
module can_txmb_arb #(
    parameter int N     = 3,
    parameter int KW    = 29,
    localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]          pend,
    input  logic [N-1:0][KW-1:0]  keys,
    input  logic [N-1:0][N-1:0]   older,
    input  logic                  order_mode,
    output logic                  gnt_vld,
    output logic [IW-1:0]         gnt_idx
);
    logic [KW-1:0] best;

    always_comb begin
        gnt_vld = 1'b0;
        gnt_idx = '0;
        best    = '0;
        for (int i = 0; i < N; i++) begin
            if (pend[i]) begin
                if (!gnt_vld || (order_mode ? older[i][gnt_idx] : (keys[i] < best))) begin
                    gnt_vld = 1'b1;
                    gnt_idx = IW'(i);
                    best    = keys[i];
                end
            end
        end
    end
endmodule

// File: rtl/can_txmb_ctrl.sv
module can_txmb_ctrl
    import can_txmb_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_wr,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic [WORD_W-1:0]      reg_wdata,
    output logic [WORD_W-1:0]      reg_rdata,
    output logic                   tx_req,
    output logic [MB_IW-1:0]       tx_mbox,
    output logic [WORD_W-1:0]      tx_ident,
    output logic [DLC_W-1:0]       tx_dlc,
    output logic [2*WORD_W-1:0]    tx_data,
    input  logic                   tx_done,
    input  logic                   tx_ok,
    output logic                   irq
);
    ctl_st_t                     st_d, st_q;
    logic [MB_N-1:0]             req_set;
    logic [MB_N-1:0][MB_N-1:0]   older;
    logic [MB_N-1:0][KEY_W-1:0]  keys;
    logic                        gnt_vld;
    logic [MB_IW-1:0]            gnt_idx;
    logic                        wr_stat;
    logic [WORD_W-1:0]           stat_w;
    mbox_t                       cur_mb;

    function automatic logic [ADDR_W-1:0] mb_addr(input int m, input int w);
        return ADDR_W'(A_MB_BASE + MB_STRIDE * m + w);
    endfunction

    always_comb begin
        stat_w = '0;
        for (int m = 0; m < MB_N; m++) begin
            stat_w[ST_STRIDE*m]             = st_q.rqcp[m];
            stat_w[ST_STRIDE*m + ST_OK_OFS] = st_q.txok[m];
            stat_w[ST_STRIDE*m + ST_AB_OFS] = st_q.abrq[m];
            stat_w[ST_EMP_BASE + m]         = st_q.empty[m];
        end
    end

    always_comb begin
        for (int m = 0; m < MB_N; m++) keys[m] = st_q.mb[m].id[WORD_W-1:3];
    end

    can_txmb_age #(.N(MB_N)) u_age (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (req_set),
        .older (older)
    );

    can_txmb_arb #(.N(MB_N), .KW(KEY_W)) u_arb (
        .pend       (~st_q.empty),
        .keys       (keys),
        .older      (older),
        .order_mode (st_q.order_mode),
        .gnt_vld    (gnt_vld),
        .gnt_idx    (gnt_idx)
    );

    assign wr_stat = reg_wr && (reg_addr == ADDR_W'(A_STAT));

    always_comb begin
        st_d    = st_q;
        req_set = '0;
        // completion flags cleared by writing one
        if (wr_stat) begin
            for (int m = 0; m < MB_N; m++) begin
                if (reg_wdata[ST_STRIDE*m]) begin
                    st_d.rqcp[m] = 1'b0;
                    st_d.txok[m] = 1'b0;
                end
            end
        end
        // outcome of the attempt in flight
        if (st_q.busy && tx_done) begin
            st_d.busy = 1'b0;
            for (int m = 0; m < MB_N; m++) begin
                if (st_q.cur == MB_IW'(m)) begin
                    if (tx_ok || st_q.no_retx || st_q.abrq[m]) begin
                        st_d.rqcp[m]  = 1'b1;
                        st_d.txok[m]  = tx_ok;
                        st_d.empty[m] = 1'b1;
                        st_d.abrq[m]  = 1'b0;
                    end
                end
            end
        end
        // abort requests
        if (wr_stat) begin
            for (int m = 0; m < MB_N; m++) begin
                if (reg_wdata[ST_STRIDE*m + ST_AB_OFS] && !st_d.empty[m]) begin
                    if (st_q.busy && (st_q.cur == MB_IW'(m)) && !tx_done) begin
                        st_d.abrq[m] = 1'b1;
                    end else begin
                        st_d.rqcp[m]  = 1'b1;
                        st_d.txok[m]  = 1'b0;
                        st_d.empty[m] = 1'b1;
                        st_d.abrq[m]  = 1'b0;
                    end
                end
            end
        end
        // control word
        if (reg_wr && (reg_addr == ADDR_W'(A_CTRL))) begin
            st_d.order_mode = reg_wdata[0];
            st_d.no_retx    = reg_wdata[1];
            st_d.irq_en     = reg_wdata[2];
        end
        // mailbox words, accepted only while the mailbox is empty
        for (int m = 0; m < MB_N; m++) begin
            if (reg_wr && st_q.empty[m]) begin
                if (reg_addr == mb_addr(m, W_ID)) begin
                    st_d.mb[m].id = reg_wdata[WORD_W-1:1];
                    if (reg_wdata[0]) begin
                        st_d.empty[m] = 1'b0;
                        st_d.rqcp[m]  = 1'b0;
                        st_d.txok[m]  = 1'b0;
                        req_set[m]    = 1'b1;
                    end
                end
                if (reg_addr == mb_addr(m, W_LEN)) st_d.mb[m].dlc = reg_wdata[DLC_W-1:0];
                if (reg_addr == mb_addr(m, W_DLO)) st_d.mb[m].dlo = reg_wdata;
                if (reg_addr == mb_addr(m, W_DHI)) st_d.mb[m].dhi = reg_wdata;
            end
        end
        // hand the next mailbox to the transmitter
        if (!st_q.busy && gnt_vld) begin
            for (int m = 0; m < MB_N; m++) begin
                if (gnt_idx == MB_IW'(m) && !st_d.empty[m]) begin
                    st_d.busy = 1'b1;
                    st_d.cur  = gnt_idx;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.empty <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cur_mb = st_q.mb[0];
        for (int m = 0; m < MB_N; m++)
            if (st_q.cur == MB_IW'(m)) cur_mb = st_q.mb[m];
    end

    assign tx_req   = st_q.busy;
    assign tx_mbox  = st_q.cur;
    assign tx_ident = {cur_mb.id, 1'b0};
    assign tx_dlc   = cur_mb.dlc;
    assign tx_data  = {cur_mb.dhi, cur_mb.dlo};
    assign irq      = st_q.irq_en && (|st_q.rqcp);

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(A_CTRL))
            reg_rdata = {29'b0, st_q.irq_en, st_q.no_retx, st_q.order_mode};
        if (reg_addr == ADDR_W'(A_STAT))
            reg_rdata = stat_w;
        for (int m = 0; m < MB_N; m++) begin
            if (reg_addr == mb_addr(m, W_ID))  reg_rdata = {st_q.mb[m].id, ~st_q.empty[m]};
            if (reg_addr == mb_addr(m, W_LEN)) reg_rdata = {{(WORD_W-DLC_W){1'b0}}, st_q.mb[m].dlc};
            if (reg_addr == mb_addr(m, W_DLO)) reg_rdata = st_q.mb[m].dlo;
            if (reg_addr == mb_addr(m, W_DHI)) reg_rdata = st_q.mb[m].dhi;
        end
    end

    // R2
    offer_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && !tx_done) |=> (tx_req && $stable(tx_mbox) && $stable(tx_ident)));
    // R2
    offer_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |-> !st_q.empty[tx_mbox]);
    // R3
    done_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && tx_done && tx_ok) |=> (st_q.empty[$past(tx_mbox)] && st_q.txok[$past(tx_mbox)] && !tx_req));
    // R4
    no_retx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && tx_done && !tx_ok && st_q.no_retx) |=> (st_q.empty[$past(tx_mbox)] && !st_q.txok[$past(tx_mbox)]));
    // R6
    done_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rqcp & ~st_q.empty) == '0);
    // R10
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (st_q.irq_en && (st_q.rqcp != '0)));
endmodule

// File: tb/can_txmb_ctrl_tb.sv
module can_txmb_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_req;
    logic [1:0]  tx_mbox;
    logic [31:0] tx_ident;
    logic [3:0]  tx_dlc;
    logic [63:0] tx_data;
    logic        tx_done = 1'b0;
    logic        tx_ok = 1'b0;
    logic        irq;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_txmb_ctrl #(.ADDR_W(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_req(tx_req),
        .tx_mbox(tx_mbox), .tx_ident(tx_ident), .tx_dlc(tx_dlc), .tx_data(tx_data),
        .tx_done(tx_done), .tx_ok(tx_ok), .irq(irq)
    );

    typedef struct packed {
        logic       mode;
        logic [7:0] k0, k1, k2;
        logic [1:0] o0, o1, o2, e2, e3;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 8'd5, 8'd3, 8'd9, 2'd0, 2'd1, 2'd2, 2'd1, 2'd2},
        '{1'b0, 8'd5, 8'd9, 8'd3, 2'd0, 2'd1, 2'd2, 2'd2, 2'd1},
        '{1'b0, 8'd7, 8'd7, 8'd7, 2'd2, 2'd1, 2'd0, 2'd0, 2'd1},
        '{1'b1, 8'd1, 8'd2, 8'd3, 2'd0, 2'd2, 2'd1, 2'd2, 2'd1},
        '{1'b1, 8'd0, 8'd5, 8'd5, 2'd1, 2'd2, 2'd0, 2'd2, 2'd0},
        '{1'b0, 8'd0, 8'd5, 8'd5, 2'd1, 2'd2, 2'd0, 2'd0, 2'd2}
    };

    function automatic logic [3:0] mb_id(input logic [1:0] m);
        return 4'(4 + 4 * m);
    endfunction

    function automatic logic [7:0] key_of(input vec_t v, input logic [1:0] m);
        return (m == 2'd0) ? v.k0 : ((m == 2'd1) ? v.k1 : v.k2);
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_req();
        for (int k = 0; k < 20 && !tx_req; k++) @(negedge clk);
    endtask

    task automatic finish_tx(input logic ok);
        tx_done = 1'b1; tx_ok = ok;
        @(negedge clk);
        tx_done = 1'b0; tx_ok = 1'b0;
    endtask

    logic [31:0] rv;

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(4'd1, rv); check("R1 status", 64'(rv), 64'h1C000000);
        rd(4'd0, rv); check("R1 ctrl", 64'(rv), 64'h0);
        check("R1 tx_req", 64'(tx_req), 64'h0);
        check("R1 irq", 64'(irq), 64'h0);

        // R2 fill mailbox 1 and request
        wr(4'd9, 32'h8);
        wr(4'd10, 32'h03020100);
        wr(4'd11, 32'h07060504);
        wr(4'd8, 32'h24600003);
        rd(4'd1, rv); check("R2 empty flag cleared", 64'(rv), 64'h14000000);
        rd(4'd8, rv); check("R2 request bit", 64'(rv), 64'h24600003);
        wait_req();
        check("R2 tx_req", 64'(tx_req), 64'h1);
        check("R2 tx_mbox", 64'(tx_mbox), 64'h1);
        check("R2 tx_ident", 64'(tx_ident), 64'h24600002);
        check("R2 tx_dlc", 64'(tx_dlc), 64'h8);
        check("R2 tx_data", tx_data, 64'h0706050403020100);

        // R9 writes to a busy mailbox are ignored
        wr(4'd9, 32'h3);
        wr(4'd10, 32'hFFFFFFFF);
        rd(4'd9, rv);  check("R9 length kept", 64'(rv), 64'h8);
        rd(4'd10, rv); check("R9 data kept", 64'(rv), 64'h03020100);

        // R3 success
        finish_tx(1'b1);
        rd(4'd1, rv); check("R3 status", 64'(rv), 64'h1C000300);
        check("R3 tx_req low", 64'(tx_req), 64'h0);
        rd(4'd8, rv); check("R3 request bit clear", 64'(rv), 64'h24600002);

        // R10 and R5
        check("R10 irq disabled", 64'(irq), 64'h0);
        wr(4'd0, 32'h4);
        check("R10 irq enabled", 64'(irq), 64'h1);
        wr(4'd1, 32'h0);
        rd(4'd1, rv); check("R5 zero write", 64'(rv), 64'h1C000300);
        wr(4'd1, 32'h100);
        rd(4'd1, rv); check("R5 clear", 64'(rv), 64'h1C000000);
        check("R10 irq after clear", 64'(irq), 64'h0);
        wr(4'd0, 32'h0);

        // R4 retry then final failure
        wr(4'd4, 32'h00000081);
        wait_req();
        finish_tx(1'b0);
        rd(4'd1, rv); check("R4 retry keeps pending", 64'(rv), 64'h18000000);
        wait_req();
        check("R4 offered again", 64'({tx_req, tx_mbox}), 64'h4);
        wr(4'd0, 32'h2);
        finish_tx(1'b0);
        rd(4'd1, rv); check("R4 no retransmission", 64'(rv), 64'h1C000001);
        wr(4'd1, 32'h1);
        wr(4'd0, 32'h0);

        // R6 abort waiting and in-flight mailboxes
        wr(4'd4, 32'h00000041);
        wr(4'd12, 32'h00000021);
        wait_req();
        check("R6 first in flight", 64'(tx_mbox), 64'h0);
        wr(4'd1, 32'h00800000);
        rd(4'd1, rv); check("R6 abort waiting", 64'(rv), 64'h18010000);
        wr(4'd1, 32'h00000080);
        rd(4'd1, rv); check("R6 abort flag in flight", 64'(rv), 64'h18010080);
        check("R6 still offered", 64'(tx_req), 64'h1);
        finish_tx(1'b0);
        rd(4'd1, rv); check("R6 aborted fail final", 64'(rv), 64'h1C010001);
        wr(4'd1, 32'h00010101);
        wr(4'd4, 32'h00000041);
        wait_req();
        wr(4'd1, 32'h00000080);
        finish_tx(1'b1);
        rd(4'd1, rv); check("R6 aborted but sent", 64'(rv), 64'h1C000003);
        wr(4'd1, 32'h00000001);
        wr(4'd1, 32'h00008000);
        rd(4'd1, rv); check("R6 abort on empty ignored", 64'(rv), 64'h1C000000);

        // R7 / R8 selection table
        foreach (VECS[i]) begin
            vec_t v;
            string tg;
            v = VECS[i];
            tg = v.mode ? "R8 request order" : "R7 identifier order";
            wr(4'd0, {31'b0, v.mode});
            wr(mb_id(v.o0), {21'b0, key_of(v, v.o0), 3'b001});
            wr(mb_id(v.o1), {21'b0, key_of(v, v.o1), 3'b001});
            wr(mb_id(v.o2), {21'b0, key_of(v, v.o2), 3'b001});
            wait_req();
            check({tg, " first"}, 64'(tx_mbox), 64'(v.o0));
            finish_tx(1'b1);
            wait_req();
            check({tg, " second"}, 64'(tx_mbox), 64'(v.e2));
            finish_tx(1'b1);
            wait_req();
            check({tg, " third"}, 64'(tx_mbox), 64'(v.e3));
            finish_tx(1'b1);
            wr(4'd1, 32'h00010101);
        end
        rd(4'd1, rv); check("R1 idle after table", 64'(rv), 64'h1C000000);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule